// File: doc/BRIEF.md
# DRAM Power-Up and Distributed Refresh Sequencer

This block takes an asynchronous DRAM array from power-up to a usable state and then keeps its cells alive. Once reset is released it counts a start-up delay, then runs a fixed burst of warm-up cycles of the CAS-before-RAS kind. After the burst it raises a sticky ready flag, and from then on it owes one refresh cycle at each expiry of a programmable interval timer. The memory's internal row counter picks the row, so the block drives no address.

The block shares the RAS, CAS and WE pins with an access controller. Whenever a cycle is owed it raises a bus request. It places strobes on the bus only while the grant is held, and it flags ownership with a drive-enable output that the pin multiplexer uses. Every rank sees the same strobes, so all ranks refresh together. Write-enable is always held inactive, which keeps any refresh cycle from being taken as a test-mode entry. Refreshes that fall due while the grant is withheld are counted up to a limit and then run back to back.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, every `ras_n` and `cas_n` bit is 1, `we_n` is 1, and `bus_req`, `drive_en` and `ready` are 0.
- R2: `bus_req` stays 0 for at least `STARTUP_CYC` clock cycles after reset is released.
- R3: After the start-up delay exactly `INIT_CNT` refresh cycles run before any periodic one. `ready` stays 0 until the last of them releases its strobes, is 1 in the first cycle after that release, and then stays 1 until reset.
- R4: Each refresh cycle drives `cas_n` low with `ras_n` high for `CAS_LEAD_CYC` cycles. It then drives `ras_n` low with `cas_n` still low for `RAS_LOW_CYC` cycles. Finally it holds both high for `RAS_HIGH_CYC` cycles, with `drive_en` still 1, before it releases the bus.
- R5: All `RANKS` bits of `ras_n` are equal at all times, and so are all bits of `cas_n`.
- R6: `we_n` is 1 at all times.
- R7: A low strobe bit or `drive_en`=1 occurs only while `bus_gnt` is 1. `bus_req` rises when a cycle is owed and stays 1, waiting for as long as needed, until that cycle's precharge completes.
- R8: Once `ready` is 1, one refresh falls due every `INTERVAL_CYC` cycles. When grants arrive within a few cycles, exactly one refresh cycle runs per interval and no others run.
- R9: Refreshes that fall due while the grant is withheld accumulate, up to `DEBT_MAX`. Any further ones are dropped. When the grant returns, the owed cycles run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_gnt | input | 1 | Grant of the shared strobe bus from the access controller |
| bus_req | output | 1 | Request for the shared strobe bus |
| drive_en | output | 1 | 1 while this block owns and drives the strobes |
| ras_n | output | RANKS | Row strobes, active low, one per rank |
| cas_n | output | RANKS | Column strobes, active low, one per rank |
| we_n | output | 1 | Write enable, held inactive (1) |
| ready | output | 1 | Start-up delay and warm-up burst complete; sticky until reset |

## Verification
The bench holds back the grant by varying delays during the warm-up burst. A design that drove strobes before the grant, or that shortened the CAS lead, would show the wrong phase lengths. It would also set the ready flag on the wrong cycle. The bench then withholds the grant for two intervals and later for six. A design that forgot the owed cycles would run too few refreshes after the grant returns. A design that did not saturate the count would run too many.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

   // strobe sequencer phases
   typedef enum logic [2:0] {
      ST_IDLE,   // nothing owed
      ST_REQ,    // bus requested, waiting for grant
      ST_LEAD,   // CAS low, RAS high
      ST_ACT,    // RAS and CAS low
      ST_PRE     // both high, bus still held
   } strobe_st_t;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/dram_rfsh_timer.sv
module dram_rfsh_timer #(
   parameter int LIMIT = 1500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   localparam int CW = $clog2(LIMIT + 1);

   logic [CW-1:0] cnt;

   assign tick = en && (cnt == CW'(LIMIT - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (tick)
         cnt <= '0;
      else if (en)
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/dram_rfsh_debt.sv
module dram_rfsh_debt #(
   parameter int DEBT_MAX = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic due,
   input  logic served,
   output logic owed_any
);
   localparam int OW = $clog2(DEBT_MAX + 1);

   logic [OW-1:0] owed;
   logic          add;

   // a due tick is lost only when the count is full and none is served
   assign add      = due && ((owed != OW'(DEBT_MAX)) || served);
   assign owed_any = (owed != '0);

   always_ff @(posedge clk) begin
      if (!rst_n)
         owed <= '0;
      else if (add && !served)
         owed <= owed + 1'b1;
      else if (!add && served)
         owed <= owed - 1'b1;
   end
endmodule

// File: rtl/dram_rfsh_strobe.sv
module dram_rfsh_strobe
   import dram_rfsh_pkg::*;
#(
   parameter int RANKS        = 2,
   parameter int CAS_LEAD_CYC = 1,
   parameter int RAS_LOW_CYC  = 6,
   parameter int RAS_HIGH_CYC = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             bus_gnt,
   output logic             bus_req,
   output logic             drive_en,
   output logic [RANKS-1:0] ras_n,
   output logic [RANKS-1:0] cas_n,
   output logic             done
);
   localparam int PH_MAX = max3(CAS_LEAD_CYC, RAS_LOW_CYC, RAS_HIGH_CYC);
   localparam int PW     = $clog2(PH_MAX + 1);

   strobe_st_t    st;
   logic [PW-1:0] ph;
   logic          ras_lvl, cas_lvl;

   assign done     = (st == ST_PRE) && (ph == PW'(RAS_HIGH_CYC - 1));
   assign bus_req  = (st != ST_IDLE);
   assign drive_en = (st == ST_LEAD) || (st == ST_ACT) || (st == ST_PRE);
   assign cas_lvl  = !((st == ST_LEAD) || (st == ST_ACT));
   assign ras_lvl  = !(st == ST_ACT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= ST_IDLE;
         ph <= '0;
      end else begin
         case (st)
            ST_IDLE: if (go) st <= ST_REQ;
            ST_REQ: if (bus_gnt) begin
               st <= ST_LEAD;
               ph <= '0;
            end
            ST_LEAD: if (ph == PW'(CAS_LEAD_CYC - 1)) begin
               st <= ST_ACT;
               ph <= '0;
            end else ph <= ph + 1'b1;
            ST_ACT: if (ph == PW'(RAS_LOW_CYC - 1)) begin
               st <= ST_PRE;
               ph <= '0;
            end else ph <= ph + 1'b1;
            ST_PRE: if (done) begin
               st <= ST_IDLE;
               ph <= '0;
            end else ph <= ph + 1'b1;
            default: st <= ST_IDLE;
         endcase
      end
   end

   // one copy of the strobes per rank, all ranks in step
   for (genvar g = 0; g < RANKS; g++) begin : g_rank
      assign ras_n[g] = ras_lvl;
      assign cas_n[g] = cas_lvl;
   end
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
   parameter int RANKS        = 2,
   parameter int STARTUP_CYC  = 20000,
   parameter int INIT_CNT     = 8,
   parameter int INTERVAL_CYC = 1500,
   parameter int CAS_LEAD_CYC = 1,
   parameter int RAS_LOW_CYC  = 6,
   parameter int RAS_HIGH_CYC = 4,
   parameter int DEBT_MAX     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_gnt,
   output logic             bus_req,
   output logic             drive_en,
   output logic [RANKS-1:0] ras_n,
   output logic [RANKS-1:0] cas_n,
   output logic             we_n,
   output logic             ready
);
   localparam int IW = $clog2(INIT_CNT + 1);

   if (RANKS < 1 || INIT_CNT < 1 || DEBT_MAX < 1) begin : g_bad_count
      $error("dram_refresh_seq: RANKS, INIT_CNT and DEBT_MAX must be at least 1");
   end
   if (CAS_LEAD_CYC < 1 || RAS_LOW_CYC < 1 || RAS_HIGH_CYC < 1) begin : g_bad_phase
      $error("dram_refresh_seq: every strobe phase needs at least one cycle");
   end
   if (STARTUP_CYC < 2 || INTERVAL_CYC < 2) begin : g_bad_timer
      $error("dram_refresh_seq: timer limits must be at least 2");
   end

   logic          start_done, start_tick;
   logic          period_tick, owed_any;
   logic          go, done, periodic_done;
   logic [IW-1:0] init_left;

   dram_rfsh_timer #(.LIMIT(STARTUP_CYC)) u_start (
      .clk(clk), .rst_n(rst_n), .en(!start_done), .tick(start_tick)
   );

   dram_rfsh_timer #(.LIMIT(INTERVAL_CYC)) u_period (
      .clk(clk), .rst_n(rst_n), .en(ready), .tick(period_tick)
   );

   assign periodic_done = done && (init_left == '0);

   dram_rfsh_debt #(.DEBT_MAX(DEBT_MAX)) u_debt (
      .clk(clk), .rst_n(rst_n), .due(period_tick),
      .served(periodic_done), .owed_any(owed_any)
   );

   assign go = start_done && ((init_left != '0) || owed_any);

   dram_rfsh_strobe #(
      .RANKS(RANKS), .CAS_LEAD_CYC(CAS_LEAD_CYC),
      .RAS_LOW_CYC(RAS_LOW_CYC), .RAS_HIGH_CYC(RAS_HIGH_CYC)
   ) u_strobe (
      .clk(clk), .rst_n(rst_n), .go(go), .bus_gnt(bus_gnt),
      .bus_req(bus_req), .drive_en(drive_en),
      .ras_n(ras_n), .cas_n(cas_n), .done(done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_done <= 1'b0;
         init_left  <= IW'(INIT_CNT);
         ready      <= 1'b0;
      end else begin
         if (start_tick)
            start_done <= 1'b1;
         if (done && (init_left != '0))
            init_left <= init_left - 1'b1;
         if (done && (init_left == IW'(1)))
            ready <= 1'b1;
      end
   end

   // refresh cycles always keep write enable inactive
   assign we_n = 1'b1;
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
   parameter int RANKS        = 2,
   parameter int STARTUP_CYC  = 20000,
   parameter int RAS_LOW_CYC  = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_gnt,
   input logic             bus_req,
   input logic             drive_en,
   input logic [RANKS-1:0] ras_n,
   input logic [RANKS-1:0] cas_n,
   input logic             ready
);
   localparam int SW = $clog2(STARTUP_CYC + 1);
   localparam int LW = $clog2(RAS_LOW_CYC + 2);

   logic [SW-1:0] since_rst;
   logic [LW-1:0] low_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_rst <= '0;
         low_cnt   <= '0;
      end else begin
         if (since_rst != SW'(STARTUP_CYC))
            since_rst <= since_rst + 1'b1;
         if (!ras_n[0] && low_cnt != {LW{1'b1}})
            low_cnt <= low_cnt + 1'b1;
         else if (ras_n[0])
            low_cnt <= '0;
      end
   end

   // R2
   startup_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> (since_rst == SW'(STARTUP_CYC)));

   // R3
   ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ready);

   // R4
   cas_before_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n[0]) |-> ($past(cas_n[0]) == 1'b0));

   // R4
   ras_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n[0]) |-> (low_cnt == LW'(RAS_LOW_CYC)));

   // R5
   rank_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((ras_n == {RANKS{1'b0}}) || (ras_n == {RANKS{1'b1}})) &&
      ((cas_n == {RANKS{1'b0}}) || (cas_n == {RANKS{1'b1}})));

   // R7
   strobe_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((ras_n != {RANKS{1'b1}}) || (cas_n != {RANKS{1'b1}}) || drive_en)
         |-> (bus_gnt && bus_req));
endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(
   .RANKS(RANKS), .STARTUP_CYC(STARTUP_CYC), .RAS_LOW_CYC(RAS_LOW_CYC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_gnt(bus_gnt), .bus_req(bus_req),
   .drive_en(drive_en), .ras_n(ras_n), .cas_n(cas_n), .ready(ready)
);

// File: tb/tb_dram_refresh_seq.sv
module tb_dram_refresh_seq;
   localparam int RANKS = 2;
   localparam int S     = 300;
   localparam int INIT  = 8;
   localparam int P     = 200;
   localparam int LEAD  = 1;
   localparam int ACT   = 6;
   localparam int PRE   = 4;
   localparam int DMAX  = 4;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             bus_gnt;
   logic             bus_req, drive_en, we_n, ready;
   logic [RANKS-1:0] ras_n, cas_n;

   always #5 clk = ~clk;

   dram_refresh_seq #(
      .RANKS(RANKS), .STARTUP_CYC(S), .INIT_CNT(INIT), .INTERVAL_CYC(P),
      .CAS_LEAD_CYC(LEAD), .RAS_LOW_CYC(ACT), .RAS_HIGH_CYC(PRE), .DEBT_MAX(DMAX)
   ) dut (
      .clk(clk), .rst_n(rst_n), .bus_gnt(bus_gnt), .bus_req(bus_req),
      .drive_en(drive_en), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ready(ready)
   );

   int total = 0, bad = 0;
   int cyc = 0;
   int exp_q[$];           // 0 = warm-up cycle, 1 = periodic cycle
   bit block = 1'b0;
   int gdelay = 0;
   int wcnt = 0;
   bit seen_ready = 1'b0, seen_req = 1'b0;
   int tr = 0;
   int init_seen = 0;
   bit in_cyc = 1'b0;
   int n_lead = 0, n_act = 0, n_pre = 0;
   bit cyc_kind = 1'b0;
   bit fl_gnt = 1'b0, fl_rank = 1'b0, fl_we = 1'b0, fl_order = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic push_exp(input int n, input int kind);
      for (int i = 0; i < n; i++) exp_q.push_back(kind);
   endtask

   task automatic wait_half(input int halves);
      while (cyc < tr + halves * (P / 2)) @(negedge clk);
   endtask

   task automatic finish_run;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   always @(posedge clk) if (rst_n === 1'b1) cyc <= cyc + 1;

   // grant driver for the access-controller side
   always @(negedge clk) begin
      if (rst_n !== 1'b1 || !bus_req) begin
         bus_gnt <= 1'b0;
         wcnt = 0;
      end else if (!block) begin
         if (wcnt >= gdelay) bus_gnt <= 1'b1;
         wcnt++;
      end
   end

   // monitor: measures each refresh cycle and pops the scoreboard
   always @(negedge clk) begin
      if (rst_n === 1'b1) begin
         if (we_n !== 1'b1) fl_we = 1'b1;
         if (!(ras_n == '0 || ras_n == '1) || !(cas_n == '0 || cas_n == '1)) fl_rank = 1'b1;
         if ((drive_en || ras_n != '1 || cas_n != '1) && !bus_gnt) fl_gnt = 1'b1;
         if (!drive_en && (ras_n != '1 || cas_n != '1)) fl_gnt = 1'b1;
         if (bus_req && !seen_req) begin
            seen_req = 1'b1;
            // R2
            chk(cyc >= S, "R2 startup wait", cyc, S);
         end
         if (seen_ready && !ready) chk(1'b0, "R3 ready dropped", 0, 1);
         if (ready && !seen_ready) begin
            seen_ready = 1'b1;
            tr = cyc;
         end
         if (drive_en) begin
            if (!in_cyc) begin
               in_cyc = 1'b1;
               n_lead = 0; n_act = 0; n_pre = 0;
               cyc_kind = ready;
            end
            if (ras_n[0] == 1'b0) begin
               n_act++;
               if (cas_n[0] != 1'b0) fl_order = 1'b1;
            end else if (cas_n[0] == 1'b0 && n_act == 0) n_lead++;
            else n_pre++;
         end else if (in_cyc) begin
            in_cyc = 1'b0;
            // R4
            chk(n_lead == LEAD, "R4 cas lead", n_lead, LEAD);
            chk(n_act == ACT, "R4 ras low", n_act, ACT);
            chk(n_pre == PRE, "R4 precharge", n_pre, PRE);
            if (exp_q.size() == 0) chk(1'b0, "R8/R9 unexpected refresh", 1, 0);
            else begin
               int k;
               k = exp_q.pop_front();
               chk(int'(cyc_kind) == k, "R3 cycle kind", int'(cyc_kind), k);
            end
            if (!cyc_kind) init_seen++;
            // R3
            chk(int'(ready) == int'(init_seen >= INIT), "R3 ready timing",
                int'(ready), int'(init_seen >= INIT));
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      chk(1'b0, "watchdog", cyc, 0);
      finish_run();
   end

   initial begin
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R1
      chk(ras_n == '1, "R1 ras_n reset", int'(ras_n), 3);
      chk(cas_n == '1, "R1 cas_n reset", int'(cas_n), 3);
      chk(we_n == 1'b1, "R1 we_n reset", int'(we_n), 1);
      chk(!bus_req && !drive_en, "R1 bus idle", int'({bus_req, drive_en}), 0);
      chk(!ready, "R1 ready reset", int'(ready), 0);
      push_exp(INIT, 0);
      gdelay = 2;
      rst_n = 1'b1;
      while (!seen_ready) @(negedge clk);
      wait_half(1);
      // R3
      chk(exp_q.size() == 0, "R3 warm-up count", INIT - exp_q.size(), INIT);
      chk(init_seen == INIT, "R3 warm-up seen", init_seen, INIT);

      // R8: steady refresh, one per interval
      push_exp(3, 1);
      gdelay = 1;
      wait_half(7);
      chk(exp_q.size() == 0, "R8 periodic count", 3 - exp_q.size(), 3);

      // R9: grant withheld for two intervals, debt below the limit
      block = 1'b1;
      wait_half(11);
      chk(bus_req == 1'b1, "R9 request held while owed", int'(bus_req), 1);
      push_exp(4, 1);
      block = 1'b0;
      gdelay = 3;
      wait_half(15);
      chk(exp_q.size() == 0, "R9 owed cycles serviced", 4 - exp_q.size(), 4);

      // R9: grant withheld for six intervals, debt saturates
      block = 1'b1;
      wait_half(27);
      chk(bus_req == 1'b1, "R7 request waits for grant", int'(bus_req), 1);
      push_exp(DMAX + 2, 1);
      block = 1'b0;
      gdelay = 0;
      wait_half(31);
      chk(exp_q.size() == 0, "R9 saturated debt", DMAX + 2 - exp_q.size(), DMAX + 2);

      // R5 R6 R7 R4 over the whole run
      chk(!fl_rank, "R5 ranks in step", int'(fl_rank), 0);
      chk(!fl_we, "R6 we_n high", int'(fl_we), 0);
      chk(!fl_gnt, "R7 strobes only under grant", int'(fl_gnt), 0);
      chk(!fl_order, "R4 cas low during ras low", int'(fl_order), 0);
      chk(ready, "R3 ready still high", int'(ready), 1);
      finish_run();
   end
endmodule